// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block supervises a microcontroller by requiring it to issue trigger commands at the right moments. The time base is an external tick. Each tick is one watchdog cycle. The trigger arrives as a one-cycle strobe, already decoded from a serial command elsewhere in the chip.

When the supervised processor comes out of reset, the block opens a long window. One valid trigger in that window ends it. If no trigger arrives, a second long window follows quietly. If the second one also expires, the block requests a hard reset.

After the first valid trigger the block cycles through two windows:
- A closed window of fixed length. Any trigger inside it is an error.
- An open window. The first trigger inside it ends the window early and starts the next closed window.

An error counter climbs by two for every bad or missing trigger. It falls by one for every good trigger and never goes below zero. When the counter reaches the programmed limit, the block escalates from an interrupt to a hard-reset request.

Window lengths are given as codes. Each code counts in units of STEP watchdog cycles, and STEP defaults to 50. The closed, open and limit settings are captured only when a closed window begins. The surrounding configuration logic is expected to power up with closed code 46, open code 78 and limit 9. Pulling enable low returns the block to idle and clears its state.

Top module: `win_watchdog`

## Requirements
- R1: While enable is low (and after rst_n), the block is idle. irq, miss_flag and hard_reset_req are 0, err_count is 0, and triggers have no effect.
- R2: With enable high, raising rel_reset starts a long open window of LONG_TICKS ticks. A trigger in the long window is valid. It starts a closed window and lowers err_count by 1, saturating at 0.
- R3: If the first long window expires without a trigger, a second long window starts. There is no interrupt and err_count does not change.
- R4: If the second consecutive long window expires, hard_reset_req rises and stays high until enable goes low.
- R5: A closed window lasts closed_code*STEP ticks. With code 0 the open window begins on the very next clock.
- R6: A trigger in a closed window is invalid. It gives a one-clock irq pulse and adds 2 to err_count, and the closed window keeps running.
- R7: An open window lasts open_code*STEP ticks, and code 0 means STEP ticks. A trigger in it is valid: it starts the next closed window and lowers err_count by 1, saturating at 0.
- R8: An open window that expires with no trigger sets miss_flag, gives a one-clock irq pulse and adds 2 to err_count. miss_flag stays set until the block goes idle.
- R9: When an increment brings err_count to or above the latched limit, hard_reset_req rises. After that, triggers neither change err_count nor pulse irq.
- R10: closed_code, open_code and err_limit are captured only when a closed window starts. A change during a window does not alter that window.
- R11: If rel_reset falls while the block is not in the hard-reset state, the block returns to idle. err_count and miss_flag are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One watchdog cycle of time base |
| trig | input | 1 | Decoded trigger command strobe |
| enable | input | 1 | Watchdog enable |
| rel_reset | input | 1 | High once the supervised processor is out of reset |
| closed_code | input | CODE_W | Closed window length in STEP units |
| open_code | input | CODE_W | Open window length in STEP units (0 means 1) |
| err_limit | input | ERR_W | Error count that requests a hard reset |
| irq | output | 1 | One-clock interrupt pulse on a bad or missed trigger |
| miss_flag | output | 1 | Sticky flag: an open window expired with no trigger |
| hard_reset_req | output | 1 | Hard-reset request, held until disabled |
| err_count | output | ERR_W | Current error count |

## Verification
The embedded properties hold on every cycle for several behaviours:
- the idle state clears everything;
- the long windows never interrupt;
- the hard-reset request and miss_flag are sticky;
- the count is frozen once the block has escalated;
- the closed-window timer stays below its latched length.

Only the bench scenarios can show the following, by comparing with a cycle-exact reference model:
- exact window lengths, including closed code 0 and open code 0;
- the +2/−1 arithmetic and saturation of the counter;
- that configuration changes are taken only at the start of a closed window;
- the two-long-window escalation after release.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_LONG   = 3'd1,
        WS_CLOSED = 3'd2,
        WS_OPEN   = 3'd3,
        WS_FAULT  = 3'd4
    } wwd_state_e;
endpackage

// File: rtl/wwd_len_decode.sv
// Converts window codes to lengths in watchdog cycles.
module wwd_len_decode #(
    parameter int STEP   = 50,
    parameter int CODE_W = 7,
    parameter int LEN_W  = 13
) (
    input  logic [CODE_W-1:0] closed_code,
    input  logic [CODE_W-1:0] open_code,
    output logic [LEN_W-1:0]  closed_len,
    output logic [LEN_W-1:0]  open_len
);
    localparam logic [LEN_W-1:0] STEP_L = LEN_W'(STEP);

    always_comb begin
        closed_len = LEN_W'(closed_code) * STEP_L;
        if (open_code == '0) begin
            open_len = STEP_L;
        end else begin
            open_len = LEN_W'(open_code) * STEP_L;
        end
    end
endmodule

// File: rtl/wwd_err_acc.sv
// Saturating error accumulator: +PENALTY on a fault, -CREDIT on a good trigger.
module wwd_err_acc #(
    parameter int ERR_W   = 8,
    parameter int PENALTY = 2,
    parameter int CREDIT  = 1
) (
    input  logic [ERR_W-1:0] cnt,
    input  logic             inc,
    input  logic             dec,
    input  logic [ERR_W-1:0] limit,
    output logic [ERR_W-1:0] cnt_nxt,
    output logic             hit
);
    localparam int CW = ERR_W + 1;
    localparam logic [CW-1:0] MAX_C = {1'b0, {ERR_W{1'b1}}};

    logic [CW-1:0] wide;
    logic [CW-1:0] sum;

    always_comb begin
        wide = {1'b0, cnt};
        sum  = wide + CW'(PENALTY);
        if (inc) begin
            cnt_nxt = (sum > MAX_C) ? {ERR_W{1'b1}} : sum[ERR_W-1:0];
        end else if (dec) begin
            cnt_nxt = (wide < CW'(CREDIT)) ? '0 : ERR_W'(wide - CW'(CREDIT));
        end else begin
            cnt_nxt = cnt;
        end
        hit = inc && (cnt_nxt >= limit);
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int STEP       = 50,
    parameter int CODE_W     = 7,
    parameter int LONG_TICKS = 8000,
    parameter int ERR_W      = 8,
    parameter int PENALTY    = 2,
    parameter int CREDIT     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              trig,
    input  logic              enable,
    input  logic              rel_reset,
    input  logic [CODE_W-1:0] closed_code,
    input  logic [CODE_W-1:0] open_code,
    input  logic [ERR_W-1:0]  err_limit,
    output logic              irq,
    output logic              miss_flag,
    output logic              hard_reset_req,
    output logic [ERR_W-1:0]  err_count
);
    localparam int MAX_WIN = ((1 << CODE_W) - 1) * STEP;
    localparam int TOP_CNT = (MAX_WIN > LONG_TICKS) ? MAX_WIN : LONG_TICKS;
    localparam int TMR_W   = $clog2(TOP_CNT + 1);
    localparam logic [TMR_W-1:0] LONG_L = TMR_W'(LONG_TICKS);

    typedef struct packed {
        wwd_state_e       st;
        logic [TMR_W-1:0] tmr;
        logic             second;
        logic [TMR_W-1:0] cl_len;
        logic [TMR_W-1:0] op_len;
        logic [ERR_W-1:0] lim;
        logic [ERR_W-1:0] err;
        logic             irq;
        logic             miss;
        logic             hard;
    } regs_t;

    regs_t r_q, r_d;

    logic [TMR_W-1:0] cl_dec, op_dec, tmr_inc;
    logic [ERR_W-1:0] err_nxt;
    logic             err_hit;
    logic             active, ev_valid, ev_bad, ev_miss;

    wwd_len_decode #(.STEP(STEP), .CODE_W(CODE_W), .LEN_W(TMR_W)) u_len (
        .closed_code (closed_code),
        .open_code   (open_code),
        .closed_len  (cl_dec),
        .open_len    (op_dec)
    );

    // Window events feeding the accumulator
    always_comb begin
        active   = enable && rel_reset;
        tmr_inc  = r_q.tmr + 1'b1;
        ev_valid = active && trig && ((r_q.st == WS_LONG) || (r_q.st == WS_OPEN));
        ev_bad   = active && trig && (r_q.st == WS_CLOSED);
        ev_miss  = active && !trig && tick && (r_q.st == WS_OPEN) && (tmr_inc == r_q.op_len);
    end

    wwd_err_acc #(.ERR_W(ERR_W), .PENALTY(PENALTY), .CREDIT(CREDIT)) u_acc (
        .cnt     (r_q.err),
        .inc     (ev_bad || ev_miss),
        .dec     (ev_valid),
        .limit   (r_q.lim),
        .cnt_nxt (err_nxt),
        .hit     (err_hit)
    );

    always_comb begin
        logic go_closed;
        go_closed = 1'b0;
        r_d       = r_q;
        r_d.irq   = 1'b0;
        if (!enable) begin
            r_d = '0;
        end else if (r_q.st == WS_FAULT) begin
            r_d.hard = 1'b1;
        end else if (r_q.st == WS_IDLE) begin
            if (rel_reset) begin
                r_d.st     = WS_LONG;
                r_d.tmr    = '0;
                r_d.second = 1'b0;
            end
        end else if (!rel_reset) begin
            r_d = '0;
        end else begin
            unique case (r_q.st)
                WS_LONG: begin
                    if (trig) begin
                        r_d.err   = err_nxt;
                        go_closed = 1'b1;
                    end else if (tick) begin
                        if (tmr_inc == LONG_L) begin
                            if (!r_q.second) begin
                                r_d.second = 1'b1;
                                r_d.tmr    = '0;
                            end else begin
                                r_d.st   = WS_FAULT;
                                r_d.hard = 1'b1;
                            end
                        end else begin
                            r_d.tmr = tmr_inc;
                        end
                    end
                end
                WS_CLOSED: begin
                    if (ev_bad) begin
                        r_d.err = err_nxt;
                        r_d.irq = 1'b1;
                    end
                    if (ev_bad && err_hit) begin
                        r_d.st   = WS_FAULT;
                        r_d.hard = 1'b1;
                    end else if (r_q.cl_len == '0) begin
                        r_d.st  = WS_OPEN;
                        r_d.tmr = '0;
                    end else if (tick) begin
                        if (tmr_inc == r_q.cl_len) begin
                            r_d.st  = WS_OPEN;
                            r_d.tmr = '0;
                        end else begin
                            r_d.tmr = tmr_inc;
                        end
                    end
                end
                WS_OPEN: begin
                    if (trig) begin
                        r_d.err   = err_nxt;
                        go_closed = 1'b1;
                    end else if (ev_miss) begin
                        r_d.err  = err_nxt;
                        r_d.miss = 1'b1;
                        r_d.irq  = 1'b1;
                        if (err_hit) begin
                            r_d.st   = WS_FAULT;
                            r_d.hard = 1'b1;
                        end else begin
                            go_closed = 1'b1;
                        end
                    end else if (tick) begin
                        r_d.tmr = tmr_inc;
                    end
                end
                default: r_d = r_q;
            endcase
        end
        if (go_closed) begin
            r_d.st     = WS_CLOSED;
            r_d.tmr    = '0;
            r_d.cl_len = cl_dec;
            r_d.op_len = op_dec;
            r_d.lim    = err_limit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq            = r_q.irq;
    assign miss_flag      = r_q.miss;
    assign hard_reset_req = r_q.hard;
    assign err_count      = r_q.err;

    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (err_count == '0 && !hard_reset_req && !miss_flag && !irq));

    assert_long_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WS_LONG) |-> !irq);

    assert_hard_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_reset_req && enable) |=> hard_reset_req);

    assert_closed_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WS_CLOSED && r_q.cl_len != '0) |-> (r_q.tmr < r_q.cl_len));

    assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_flag && enable && rel_reset) |=> miss_flag);

    assert_fault_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WS_FAULT && enable) |=> ($stable(err_count) && !irq));
endmodule

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
    localparam int STEP  = 2;
    localparam int LONGT = 6;
    localparam int ERR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic trig = 1'b0;
    logic enable = 1'b0;
    logic rel_reset = 1'b0;
    logic [6:0] closed_code = 7'd3;
    logic [6:0] open_code = 7'd2;
    logic [ERR_W-1:0] err_limit = 8'd9;
    logic irq, miss_flag, hard_reset_req;
    logic [ERR_W-1:0] err_count;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 0;
    int tcnt = 0;

    always #4 clk = ~clk;

    win_watchdog #(.STEP(STEP), .CODE_W(7), .LONG_TICKS(LONGT), .ERR_W(ERR_W)) u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .enable(enable),
        .rel_reset(rel_reset), .closed_code(closed_code), .open_code(open_code),
        .err_limit(err_limit), .irq(irq), .miss_flag(miss_flag),
        .hard_reset_req(hard_reset_req), .err_count(err_count)
    );

    // tick every second clock
    always @(negedge clk) begin
        tcnt <= tcnt + 1;
        tick <= (tcnt % 2) == 0;
    end

    // Behavioural reference model: 0 idle, 1 long, 2 closed, 3 open, 4 fault
    int m_st, m_tmr, m_cl, m_ol, m_lim, m_err;
    bit m_second, m_irq, m_miss, m_hard;

    task automatic m_clear();
        m_st = 0; m_tmr = 0; m_cl = 0; m_ol = 0; m_lim = 0; m_err = 0;
        m_second = 0; m_irq = 0; m_miss = 0; m_hard = 0;
    endtask

    task automatic m_start_closed();
        m_st  = 2; m_tmr = 0;
        m_cl  = closed_code * STEP;
        m_ol  = (open_code == 0 ? 1 : open_code) * STEP;
        m_lim = err_limit;
    endtask

    function automatic bit m_penalize();
        m_err = (m_err + 2 > 255) ? 255 : m_err + 2;
        if (m_err >= m_lim) begin
            m_st = 4; m_hard = 1;
            return 1;
        end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_clear();
        end else begin
            m_irq = 0;
            if (!enable) m_clear();
            else if (m_st == 4) m_hard = 1;
            else if (m_st == 0) begin
                if (rel_reset) begin m_st = 1; m_tmr = 0; m_second = 0; end
            end else if (!rel_reset) m_clear();
            else if (m_st == 1) begin
                if (trig) begin
                    if (m_err > 0) m_err--;
                    m_start_closed();
                end else if (tick) begin
                    m_tmr++;
                    if (m_tmr == LONGT) begin
                        if (!m_second) begin m_second = 1; m_tmr = 0; end
                        else begin m_st = 4; m_hard = 1; end
                    end
                end
            end else if (m_st == 2) begin
                bit f;
                f = 0;
                if (trig) begin m_irq = 1; f = m_penalize(); end
                if (!f) begin
                    if (m_cl == 0) begin m_st = 3; m_tmr = 0; end
                    else if (tick) begin
                        m_tmr++;
                        if (m_tmr == m_cl) begin m_st = 3; m_tmr = 0; end
                    end
                end
            end else if (m_st == 3) begin
                if (trig) begin
                    if (m_err > 0) m_err--;
                    m_start_closed();
                end else if (tick) begin
                    m_tmr++;
                    if (m_tmr == m_ol) begin
                        m_miss = 1; m_irq = 1;
                        if (!m_penalize()) m_start_closed();
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (irq !== m_irq) begin
                n_fails++;
                $display("FAIL R6/R8 irq act=%0d exp=%0d t=%0t", irq, m_irq, $time);
            end
            if (miss_flag !== m_miss) begin
                n_fails++;
                $display("FAIL R8 miss act=%0d exp=%0d t=%0t", miss_flag, m_miss, $time);
            end
            if (hard_reset_req !== m_hard) begin
                n_fails++;
                $display("FAIL R4/R9 hard act=%0d exp=%0d t=%0t", hard_reset_req, m_hard, $time);
            end
            if (err_count !== ERR_W'(m_err)) begin
                n_fails++;
                $display("FAIL R7 err act=%0d exp=%0d t=%0t", err_count, m_err, $time);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_state(input int s);
        for (int i = 0; i < 2000 && m_st != s; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk(err_count + irq + miss_flag + hard_reset_req, 0, "R1 reset state");
        rst_n = 1'b1;
        cyc(2);
        enable = 1'b1;
        pulse_trig();
        chk(irq, 0, "R1 trigger before release irq");
        chk(err_count, 0, "R1 trigger before release err");

        // Two long windows expire with no trigger
        rel_reset = 1'b1;
        cyc(16);
        chk(hard_reset_req, 0, "R3 first long expiry no hard");
        chk(irq, 0, "R3 first long expiry no irq");
        cyc(14);
        chk(hard_reset_req, 1, "R4 second long expiry hard");
        chk(err_count, 0, "R3 long windows no error");
        cyc(4);
        chk(hard_reset_req, 1, "R4 hard held");

        enable = 1'b0;
        cyc(2);
        chk(hard_reset_req + err_count, 0, "R1 disable clears");

        // Valid trigger in long window, then a bad one in closed window
        enable = 1'b1;
        cyc(3);
        @(negedge clk); trig = 1'b1;
        @(negedge clk);
        chk(err_count, 0, "R2 long trigger saturates at zero");
        @(negedge clk); trig = 1'b0;
        chk(irq, 1, "R6 closed trigger irq");
        chk(err_count, 2, "R6 closed trigger adds two");

        // Closed code change mid-window has no effect on this window
        closed_code = 7'd0;
        cyc(2);
        pulse_trig();
        chk(irq, 1, "R10 window kept latched length");
        chk(err_count, 4, "R10 second invalid");

        wait_state(3);
        pulse_trig();
        chk(err_count, 3, "R7 open trigger subtracts one");
        chk(irq, 0, "R7 valid no irq");
        // closed code 0: open next clock
        cyc(1);
        pulse_trig();
        chk(err_count, 2, "R5 zero closed window then valid");
        chk(irq, 0, "R5 no irq");

        // Let an open window expire (open code 0 -> STEP ticks)
        open_code = 7'd0;
        closed_code = 7'd1;
        pulse_trig();
        for (int i = 0; i < 200 && !miss_flag; i++) @(negedge clk);
        chk(miss_flag, 1, "R8 miss flag set");
        chk(irq, 1, "R8 miss irq");
        chk(err_count, 3, "R8 miss adds two");

        // Release drop returns to idle
        rel_reset = 1'b0;
        cyc(2);
        chk(err_count + miss_flag, 0, "R11 release drop clears");

        // Threshold escalation
        err_limit = 8'd3;
        rel_reset = 1'b1;
        cyc(3);
        pulse_trig();
        for (int i = 0; i < 400 && !hard_reset_req; i++) @(negedge clk);
        chk(hard_reset_req, 1, "R9 threshold hard reset");
        chk(err_count, 4, "R9 count at escalation");
        pulse_trig();
        chk(irq, 0, "R9 trigger ignored irq");
        chk(err_count, 4, "R9 trigger ignored count");

        enable = 1'b0;
        cyc(2);
        chk(hard_reset_req + err_count + miss_flag, 0, "R1 final disable");

        done = 1;
        report();
        $finish;
    end
endmodule